// File: doc/BRIEF.md
# Decrementer Interval Timer with Auto-Reload

This block is a down-counter that software programs with a starting value to measure an interval. The count drops by one on every tick. A tick is a one-cycle enable pulse that comes from the same source that advances the chip's free-running time base. When a tick takes the count from one to zero, the block sets a sticky status flag. If the interrupt enable is on, it also raises a level-sensitive interrupt request. Software clears the flag by writing a one to it.

With auto-reload off, the counter halts at zero. With auto-reload on, the same tick that would produce zero loads the counter from a separate reload register instead, and counting goes on from there. The interrupt enable only masks the request. The status flag is recorded whether or not the enable is set. The time base, address decoding and the interrupt controller are outside this block.

Top module: `dec_timer`

## Requirements
- R1: On a cycle with `tick` high, no count write and a count above one, `count` falls by exactly one at the next clock edge. Without a tick, `count` holds its value.
- R2: With auto-reload off, a tick that takes `count` from 1 to 0 leaves it at 0. A tick while `count` is 0 leaves it at 0 and raises no status, whatever the auto-reload setting.
- R3: A tick that takes `count` from 1 to 0 (the zero event) sets `status` at the next edge. `status` then stays set until it is cleared.
- R4: A cycle with `clr_wr` high and `clr_bit` = 1 clears `status`. A cycle with `clr_wr` high and `clr_bit` = 0 leaves it unchanged. If a zero event and a clear fall in the same cycle, `status` ends up set.
- R5: `irq` equals `status` AND `irq_en` in every cycle. It stays high until `status` is cleared or the enable is dropped.
- R6: With auto-reload on, the zero event loads `count` with the value `reload` held before that edge, and decrementing continues from there.
- R7: A count write (`cnt_wr`) takes priority over a tick in the same cycle, so `count` takes `cnt_wdata`. A write of 0 does not set `status`.
- R8: After reset, `count`, `reload`, `status`, `irq_en`, `auto_rld` and `irq` are all 0.
- R9: `rld_wr` loads `reload` from `rld_wdata`. `ctl_wr` loads `irq_en` from `ctl_ie` and `auto_rld` from `ctl_are`. Each new value is visible one cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | One-cycle count enable shared with the time base |
| cnt_wr | input | 1 | Write strobe for the counter |
| cnt_wdata | input | W | Value written to the counter |
| rld_wr | input | 1 | Write strobe for the reload register |
| rld_wdata | input | W | Value written to the reload register |
| ctl_wr | input | 1 | Write strobe for the control bits |
| ctl_ie | input | 1 | Interrupt enable value to write |
| ctl_are | input | 1 | Auto-reload value to write |
| clr_wr | input | 1 | Write strobe for the status clear |
| clr_bit | input | 1 | 1 clears status, 0 leaves it unchanged |
| count | output | W | Current counter value |
| reload | output | W | Reload register value |
| irq_en | output | 1 | Interrupt enable bit |
| auto_rld | output | 1 | Auto-reload bit |
| status | output | 1 | Sticky zero-event flag |
| irq | output | 1 | Level interrupt request |

## Verification
Every register write, tick, zero event and clear shows up at the outputs exactly one clock edge after the cycle that carries it. `irq` is combinational from the status and enable flops, so it changes at that same edge. The bench sets each stimulus at a falling edge, lets one rising edge pass, and samples on the following falling edge before it drives the next stimulus. Each expected value in the table is therefore the state one edge after its own row.

// File: rtl/dec_pkg.sv
// Package: shared types for the decrementer timer.
// Assumes: nothing beyond a single clock domain.
package dec_pkg;
    // Control bits held by the control register.
    typedef struct packed {
        logic ie;   // interrupt request mask
        logic are;  // reload on zero event
    } dec_ctrl_t;
endpackage

// File: rtl/dec_ctrl_regs.sv
// Module: dec_ctrl_regs
// Holds the reload value and the control bits that software writes.
// Assumes: the write strobes are single-cycle pulses from bus decoding outside this block.
module dec_ctrl_regs #(
    parameter int W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rld_wr,
    input  logic [W-1:0]       rld_wdata,
    input  logic               ctl_wr,
    input  logic               ctl_ie,
    input  logic               ctl_are,
    output logic [W-1:0]       reload,
    output dec_pkg::dec_ctrl_t ctrl
);
    logic chk_live;

    // Reload register: loaded on its write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      reload <= '0;
        else if (rld_wr) reload <= rld_wdata;
    end

    // Control bits: both are loaded together on the control strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctrl <= '0;
        else if (ctl_wr) ctrl <= '{ie: ctl_ie, are: ctl_are};
    end

    // Assertion guard: high once a clocked cycle out of reset has passed.
    always_ff @(posedge clk) begin
        if (!rst_n) chk_live <= 1'b0;
        else        chk_live <= 1'b1;
    end

    // R9: without a write strobe, the registers keep their values.
    assert_ctrl_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_live && !$past(ctl_wr)) |-> $stable(ctrl));
    assert_rld_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_live && !$past(rld_wr)) |-> $stable(reload));
endmodule

// File: rtl/dec_counter.sv
// Module: dec_counter
// Down-counter with software load, halt at zero and optional reload.
// Assumes: tick is a one-cycle enable; reload and are come from registers.
module dec_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         cnt_wr,
    input  logic [W-1:0] cnt_wdata,
    input  logic [W-1:0] reload,
    input  logic         are,
    output logic [W-1:0] count,
    output logic         zero_evt
);
    localparam logic [W-1:0] ONE = W'(1);

    logic chk_live;

    // Zero event: a tick that is not overridden by a write, taking the count from one to zero.
    always_comb zero_evt = tick && !cnt_wr && (count == ONE);

    // Counter update: a write wins, then reload or decrement on a tick; zero holds.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (cnt_wr)
            count <= cnt_wdata;
        else if (zero_evt)
            count <= are ? reload : '0;
        else if (tick && count != '0)
            count <= count - ONE;
    end

    // Assertion guard: high once a clocked cycle out of reset has passed.
    always_ff @(posedge clk) begin
        if (!rst_n) chk_live <= 1'b0;
        else        chk_live <= 1'b1;
    end

    assert_step_down_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_live && $past(tick) && !$past(cnt_wr) && $past(count) > ONE)
        |-> count == $past(count) - ONE);
    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_live && !$past(tick) && !$past(cnt_wr)) |-> $stable(count));
    assert_stay_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_live && !$past(cnt_wr) && $past(count) == '0) |-> count == '0);
    assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_live && $past(zero_evt) && $past(are)) |-> count == $past(reload));
    assert_write_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_live && $past(cnt_wr)) |-> count == $past(cnt_wdata));
endmodule

// File: rtl/dec_status.sv
// Module: dec_status
// Sticky zero-event flag with write-one-to-clear, and the masked interrupt request.
// Assumes: zero_evt is a single-cycle pulse; a set wins over a clear in the same cycle.
module dec_status (
    input  logic clk,
    input  logic rst_n,
    input  logic zero_evt,
    input  logic clr_wr,
    input  logic clr_bit,
    input  logic irq_en,
    output logic status,
    output logic irq
);
    logic chk_live;

    // Sticky flag: set by the zero event, cleared by writing a one.
    always_ff @(posedge clk) begin
        if (!rst_n)                 status <= 1'b0;
        else if (zero_evt)          status <= 1'b1;
        else if (clr_wr && clr_bit) status <= 1'b0;
    end

    // Request: the flag masked by the enable.
    always_comb irq = status && irq_en;

    // Assertion guard: high once a clocked cycle out of reset has passed.
    always_ff @(posedge clk) begin
        if (!rst_n) chk_live <= 1'b0;
        else        chk_live <= 1'b1;
    end

    assert_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_live && $past(zero_evt)) |-> status);
    assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_live && $past(status) && !($past(clr_wr) && $past(clr_bit))) |-> status);
    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_live && $past(clr_wr) && $past(clr_bit) && !$past(zero_evt)) |-> !status);
    assert_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> status);
endmodule

// File: rtl/dec_timer.sv
// Module: dec_timer (top)
// Decrementer interval timer: counter, reload/control registers and sticky status.
// Assumes: one clock; software strobes and tick are synchronous single-cycle pulses.
module dec_timer #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         cnt_wr,
    input  logic [W-1:0] cnt_wdata,
    input  logic         rld_wr,
    input  logic [W-1:0] rld_wdata,
    input  logic         ctl_wr,
    input  logic         ctl_ie,
    input  logic         ctl_are,
    input  logic         clr_wr,
    input  logic         clr_bit,
    output logic [W-1:0] count,
    output logic [W-1:0] reload,
    output logic         irq_en,
    output logic         auto_rld,
    output logic         status,
    output logic         irq
);
    dec_pkg::dec_ctrl_t ctrl;
    logic               zero_evt;

    dec_ctrl_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .rld_wr(rld_wr), .rld_wdata(rld_wdata),
        .ctl_wr(ctl_wr), .ctl_ie(ctl_ie), .ctl_are(ctl_are),
        .reload(reload), .ctrl(ctrl)
    );

    dec_counter #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .reload(reload), .are(ctrl.are),
        .count(count), .zero_evt(zero_evt)
    );

    dec_status u_sts (
        .clk(clk), .rst_n(rst_n), .zero_evt(zero_evt),
        .clr_wr(clr_wr), .clr_bit(clr_bit), .irq_en(ctrl.ie),
        .status(status), .irq(irq)
    );

    // Control bits brought out for read-back.
    always_comb begin
        irq_en   = ctrl.ie;
        auto_rld = ctrl.are;
    end
endmodule

// File: tb/sim_dec_timer.sv
// Bench for dec_timer: a vector table walk, then directed reset and corner tests.
module sim_dec_timer;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0, cnt_wr = 1'b0, rld_wr = 1'b0, ctl_wr = 1'b0;
    logic         ctl_ie = 1'b0, ctl_are = 1'b0, clr_wr = 1'b0, clr_bit = 1'b0;
    logic [W-1:0] cnt_wdata = '0, rld_wdata = '0;
    logic [W-1:0] count, reload;
    logic         irq_en, auto_rld, status, irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    dec_timer #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .rld_wr(rld_wr), .rld_wdata(rld_wdata),
        .ctl_wr(ctl_wr), .ctl_ie(ctl_ie), .ctl_are(ctl_are),
        .clr_wr(clr_wr), .clr_bit(clr_bit),
        .count(count), .reload(reload), .irq_en(irq_en), .auto_rld(auto_rld),
        .status(status), .irq(irq)
    );

    // One stimulus row and the state expected one edge later.
    typedef struct packed {
        logic        tk, cw, rw, tw, ie, are, clw, clb;
        logic [31:0] data;
        logic [31:0] ecnt;
        logic        est, eirq;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{0,0,0,1,1,0,0,0, 32'd0, 32'd0, 0,0, 8'd9},  // enable on
        '{0,1,0,0,0,0,0,0, 32'd3, 32'd3, 0,0, 8'd7},  // load 3
        '{1,0,0,0,0,0,0,0, 32'd0, 32'd2, 0,0, 8'd1},
        '{0,0,0,0,0,0,0,0, 32'd0, 32'd2, 0,0, 8'd1},  // no tick, hold
        '{1,0,0,0,0,0,0,0, 32'd0, 32'd1, 0,0, 8'd1},
        '{1,0,0,0,0,0,0,0, 32'd0, 32'd0, 1,1, 8'd3},  // zero event
        '{1,0,0,0,0,0,0,0, 32'd0, 32'd0, 1,1, 8'd2},  // halted
        '{0,0,0,0,0,0,1,0, 32'd0, 32'd0, 1,1, 8'd4},  // clear with 0
        '{0,0,0,0,0,0,1,1, 32'd0, 32'd0, 0,0, 8'd4},  // clear with 1
        '{0,0,0,1,0,1,0,0, 32'd0, 32'd0, 0,0, 8'd9},  // ie off, reload on
        '{0,0,1,0,0,0,0,0, 32'd5, 32'd0, 0,0, 8'd9},  // reload value 5
        '{0,1,0,0,0,0,0,0, 32'd2, 32'd2, 0,0, 8'd7},
        '{1,0,0,0,0,0,0,0, 32'd0, 32'd1, 0,0, 8'd1},
        '{1,0,0,0,0,0,0,0, 32'd0, 32'd5, 1,0, 8'd6},  // reload, masked
        '{1,0,0,0,0,0,0,0, 32'd0, 32'd4, 1,0, 8'd6},  // keeps counting
        '{0,0,0,1,1,1,0,0, 32'd0, 32'd4, 1,1, 8'd5},  // unmask
        '{1,1,0,0,0,0,0,0, 32'd9, 32'd9, 1,1, 8'd7},  // write beats tick
        '{0,0,0,0,0,0,1,1, 32'd0, 32'd9, 0,0, 8'd4},
        '{0,1,0,0,0,0,0,0, 32'd0, 32'd0, 0,0, 8'd7},  // write 0, no status
        '{1,0,0,0,0,0,0,0, 32'd0, 32'd0, 0,0, 8'd2}   // tick at 0, reload on
    };

    task automatic check(input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        tick = 0; cnt_wr = 0; rld_wr = 0; ctl_wr = 0;
        ctl_ie = 0; ctl_are = 0; clr_wr = 0; clr_bit = 0;
        cnt_wdata = '0; rld_wdata = '0;
    endtask

    // Apply the current inputs for one edge, then sample at the next falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog: an overlong run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=0", cycles);
            finish_run();
        end
    end

    initial begin
        idle_inputs();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R8 reset state
        check("R8", "count",    count,         '0);
        check("R8", "reload",   reload,        '0);
        check("R8", "status",   W'(status),    '0);
        check("R8", "irq_en",   W'(irq_en),    '0);
        check("R8", "auto_rld", W'(auto_rld),  '0);
        check("R8", "irq",      W'(irq),       '0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            tick = VEC[i].tk; cnt_wr = VEC[i].cw; rld_wr = VEC[i].rw;
            ctl_wr = VEC[i].tw; ctl_ie = VEC[i].ie; ctl_are = VEC[i].are;
            clr_wr = VEC[i].clw; clr_bit = VEC[i].clb;
            cnt_wdata = VEC[i].data; rld_wdata = VEC[i].data;
            step();
            idle_inputs();
            check($sformatf("R%0d", VEC[i].req), $sformatf("row%0d count", i), count, VEC[i].ecnt);
            check($sformatf("R%0d", VEC[i].req), $sformatf("row%0d status", i), W'(status), W'(VEC[i].est));
            check($sformatf("R%0d", VEC[i].req), $sformatf("row%0d irq", i), W'(irq), W'(VEC[i].eirq));
        end

        // R9 read-back of reload and control bits
        check("R9", "reload",   reload,       32'd5);
        check("R9", "irq_en",   W'(irq_en),   W'(1));
        check("R9", "auto_rld", W'(auto_rld), W'(1));

        // R4 zero event and clear in the same cycle: set wins
        cnt_wr = 1; cnt_wdata = 32'd1; step(); idle_inputs();
        tick = 1; clr_wr = 1; clr_bit = 1; step(); idle_inputs();
        check("R4", "set beats clear status", W'(status), W'(1));
        check("R6", "reload after set/clear", count, 32'd5);

        // R5 dropping the enable drops the request; status stays
        ctl_wr = 1; ctl_ie = 0; ctl_are = 1; step(); idle_inputs();
        check("R5", "irq masked", W'(irq), W'(0));
        check("R3", "status kept", W'(status), W'(1));

        // R1 large value decrement
        cnt_wr = 1; cnt_wdata = 32'hFFFF_FFFF; step(); idle_inputs();
        tick = 1; step(); idle_inputs();
        check("R1", "max decrement", count, 32'hFFFF_FFFE);

        // R8 reset mid-run
        rst_n = 0; step(); rst_n = 1; @(negedge clk);
        check("R8", "count after reset",  count,      '0);
        check("R8", "reload after reset", reload,     '0);
        check("R8", "status after reset", W'(status), '0);

        finish_run();
    end
endmodule